// File: doc/BRIEF.md
# Configurable Logic Cell

This block is one programmable logic element. It holds a four-input lookup table, a carry generator that can be switched on, and a storage flop that can be switched on. A static configuration word sets all of them. The word is shifted in one bit at a time while a configuration-mode input is high. The cell has three outputs:
- the raw table result, which is always visible;
- a carry-out;
- the main cell output, which comes either from the table directly or from the flop.

The flop can capture on either clock edge. Its set/reset input can act in either of two ways. In synchronous mode it is honoured only on a clocked, enabled edge. In asynchronous mode it forces the flop at once.

Build parameters mark which of the data, enable and set/reset inputs are wired. An unwired data input or set/reset reads as 0. An unwired clock enable reads as 1. The reset input `rst_n` is asserted asynchronously and released synchronously after two rising clock edges.

Top module: `logic_cell`

## Requirements
- R1: `lut_out` equals bit `{din[3],din[2],din[1],din[0]}` of the 16-bit truth field, with `din[3]` as the most significant index bit.
- R2: With the carry-enable bit set, `cout` equals `(din[1] & din[2]) | ((din[1] | din[2]) & cin)`.
- R3: With the carry-enable bit clear, `cout` is 0 for every input pattern.
- R4: With the register-enable bit clear, `cell_out` equals `lut_out` with no clock edge in between.
- R5: With the register-enable bit set, `cell_out` takes the table result on the active clock edge when `ce` is high. It holds when `ce` is low.
- R6: In synchronous mode (async bit 0), `sr` high on an active edge with `ce` high loads the set/reset value bit. With `ce` low, the flop holds.
- R7: In asynchronous mode (async bit 1), raising `sr` drives `cell_out` to the set/reset value before any clock edge, whatever the level of `ce`.
- R8: With the clock-polarity bit 0 the flop captures on the rising edge of `clk`. With it set to 1 the flop captures on the falling edge.
- R9: `lut_out` follows the table even while the register is enabled and holding.
- R10: Inputs marked unwired by `HAS_IN`, `HAS_SR` or `HAS_CE` read as 0, 0 and 1 respectively.
- R11: While `cfg_mode` is high, each rising edge shifts `cfg_din` into the configuration word. The first bit sent ends at bit 20 after 21 shifts. The flop holds its value throughout. The word layout is:
  - bit 20: clock polarity
  - bit 19: async mode
  - bit 18: set/reset value
  - bit 17: register enable
  - bit 16: carry enable
  - bits 15:0: truth field, where bit k is entry k
- R12: After reset the configuration word is all zeros, so `lut_out`, `cout` and `cell_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| cfg_mode | input | 1 | High while configuration bits are shifted in |
| cfg_din | input | 1 | Serial configuration bit |
| din | input | 4 | Table select inputs |
| cin | input | 1 | Carry input |
| ce | input | 1 | Flop clock enable |
| sr | input | 1 | Flop set/reset request |
| cell_out | output | 1 | Main output, from the flop or from the table |
| lut_out | output | 1 | Raw table result |
| cout | output | 1 | Carry output |

## Verification
The bench looks at each flop mode for the edge where a wrong design would move.
- A falling-edge cell that still captured on the rising edge would change `cell_out` half a cycle early.
- A synchronous set/reset that ignored `ce` would load the set/reset value while it should hold.
- An asynchronous force that waited for a clock would leave `cell_out` unchanged in the middle of the cycle.

The bench also changes the configuration while the flop holds a 1. A cell that kept its flop running during the shift would pick up the partly loaded table. A second instance with unwired inputs shows whether the tie-offs read 0 or 1 as R10 requires. Flipped index bits or a swapped carry term show up as a wrong table entry or carry value during the exhaustive sweeps.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_SEL_W   = 4;
  localparam int LC_TRUTH_W = 1 << LC_SEL_W;
  localparam int LC_FLAG_W  = 5;
  localparam int LC_CFG_W   = LC_TRUTH_W + LC_FLAG_W;

  typedef struct packed {
    logic                  neg_clk;
    logic                  async_sr;
    logic                  sr_val;
    logic                  reg_en;
    logic                  carry_en;
    logic [LC_TRUTH_W-1:0] truth;
  } lc_cfg_t;
endpackage

// File: rtl/lc_rst_sync.sv
module lc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/lc_cfg_chain.sv
module lc_cfg_chain #(
  parameter int W = lc_pkg::LC_CFG_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word
);
  logic [W-1:0] word_q;
  logic [W-1:0] word_d;

  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[W-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word = word_q;
endmodule

// File: rtl/lc_lut.sv
module lc_lut #(
  parameter int SEL_W = lc_pkg::LC_SEL_W,
  localparam int ENTRIES = 1 << SEL_W
) (
  input  logic [ENTRIES-1:0] truth,
  input  logic [SEL_W-1:0]   sel,
  output logic               y
);
  assign y = truth[sel];
endmodule

// File: rtl/lc_carry.sv
module lc_carry (
  input  logic en,
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic co
);
  logic gen, prop;

  always_comb begin
    gen  = a & b;
    prop = a | b;
    co   = en & (gen | (prop & ci));
  end
endmodule

// File: rtl/lc_store.sv
module lc_store #(
  parameter bit NEG = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic d,
  input  logic sync_sr,
  input  logic sr_val,
  input  logic a_set,
  input  logic a_clr,
  output logic q
);
  logic d_nxt;

  always_comb begin
    d_nxt = sync_sr ? sr_val : d;
  end

  generate
    if (NEG) begin : g_fall
      always_ff @(negedge clk or negedge rst_n or posedge a_set or posedge a_clr) begin
        if (!rst_n)     q <= 1'b0;
        else if (a_clr) q <= 1'b0;
        else if (a_set) q <= 1'b1;
        else if (load)  q <= d_nxt;
      end
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n or posedge a_set or posedge a_clr) begin
        if (!rst_n)     q <= 1'b0;
        else if (a_clr) q <= 1'b0;
        else if (a_set) q <= 1'b1;
        else if (load)  q <= d_nxt;
      end
    end
  endgenerate
endmodule

// File: rtl/logic_cell.sv
module logic_cell #(
  parameter int              SEL_W  = lc_pkg::LC_SEL_W,
  parameter logic [SEL_W-1:0] HAS_IN = '1,
  parameter bit              HAS_SR = 1'b1,
  parameter bit              HAS_CE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_mode,
  input  logic             cfg_din,
  input  logic [SEL_W-1:0] din,
  input  logic             cin,
  input  logic             ce,
  input  logic             sr,
  output logic             cell_out,
  output logic             lut_out,
  output logic             cout
);
  import lc_pkg::*;

  localparam int EDGES = 2;

  logic             rst_s;
  lc_cfg_t          cfg;
  logic [SEL_W-1:0] din_eff;
  logic             sr_eff, ce_eff;
  logic             load, sync_sr, a_set, a_clr;
  logic [EDGES-1:0] q_edge;
  logic             q_pos, q_sel;

  lc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_s)
  );

  lc_cfg_chain #(.W(LC_CFG_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .shift_en(cfg_mode), .bit_in(cfg_din), .word(cfg)
  );

  // Unwired inputs: data and set/reset read 0, enable reads 1.
  generate
    for (genvar i = 0; i < SEL_W; i++) begin : g_in
      if (HAS_IN[i]) begin : g_wired
        assign din_eff[i] = din[i];
      end else begin : g_tied
        assign din_eff[i] = 1'b0;
      end
    end
    if (HAS_SR) begin : g_sr
      assign sr_eff = sr;
    end else begin : g_sr_tie
      assign sr_eff = 1'b0;
    end
    if (HAS_CE) begin : g_ce
      assign ce_eff = ce;
    end else begin : g_ce_tie
      assign ce_eff = 1'b1;
    end
  endgenerate

  lc_lut #(.SEL_W(SEL_W)) u_lut (
    .truth(cfg.truth), .sel(din_eff), .y(lut_out)
  );

  lc_carry u_carry (
    .en(cfg.carry_en), .a(din_eff[1]), .b(din_eff[2]), .ci(cin), .co(cout)
  );

  // Flop control: everything frozen while configuration is shifting.
  always_comb begin
    load    = ce_eff & ~cfg_mode;
    sync_sr = sr_eff & ~cfg.async_sr;
    a_set   = sr_eff & cfg.async_sr & cfg.sr_val & ~cfg_mode;
    a_clr   = sr_eff & cfg.async_sr & ~cfg.sr_val & ~cfg_mode;
  end

  generate
    for (genvar e = 0; e < EDGES; e++) begin : g_edge
      lc_store #(.NEG(e == 1)) u_store (
        .clk(clk), .rst_n(rst_s), .load(load), .d(lut_out),
        .sync_sr(sync_sr), .sr_val(cfg.sr_val),
        .a_set(a_set), .a_clr(a_clr), .q(q_edge[e])
      );
    end
  endgenerate

  always_comb begin
    q_pos    = q_edge[0];
    q_sel    = cfg.neg_clk ? q_edge[1] : q_edge[0];
    cell_out = cfg.reg_en ? q_sel : lut_out;
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker (
  input logic            clk,
  input logic            rst_s,
  input logic            cfg_mode,
  input lc_pkg::lc_cfg_t cfg,
  input logic [3:0]      din_eff,
  input logic            cin,
  input logic            ce_eff,
  input logic            sr_eff,
  input logic            q_pos,
  input logic            cell_out,
  input logic            lut_out,
  input logic            cout
);
  // R1
  a_r1_lut_index: assert property (@(posedge clk) disable iff (!rst_s)
    lut_out == cfg.truth[din_eff]);
  // R2
  a_r2_carry_on: assert property (@(posedge clk) disable iff (!rst_s)
    cfg.carry_en |-> cout == ((din_eff[1] & din_eff[2]) | ((din_eff[1] | din_eff[2]) & cin)));
  // R3
  a_r3_carry_off: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg.carry_en |-> !cout);
  // R4
  a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_s)
    !cfg.reg_en |-> cell_out == lut_out);
  // R5
  a_r5_ce_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (!ce_eff && !cfg.async_sr) |=> q_pos == $past(q_pos));
  // R6
  a_r6_sync_load: assert property (@(posedge clk) disable iff (!rst_s)
    (!cfg_mode && ce_eff && sr_eff && !cfg.async_sr && !cfg.neg_clk && cfg.reg_en)
      |=> cell_out == $past(cfg.sr_val));
  // R7
  a_r7_async_force: assert property (@(posedge clk) disable iff (!rst_s)
    (!cfg_mode && sr_eff && cfg.async_sr && cfg.reg_en) |-> cell_out == cfg.sr_val);
  // R11
  a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_s)
    cfg_mode |=> q_pos == $past(q_pos));
endmodule

bind logic_cell lc_checker u_chk (
  .clk(clk), .rst_s(rst_s), .cfg_mode(cfg_mode), .cfg(cfg), .din_eff(din_eff),
  .cin(cin), .ce_eff(ce_eff), .sr_eff(sr_eff), .q_pos(q_pos),
  .cell_out(cell_out), .lut_out(lut_out), .cout(cout)
);

// File: tb/sim_logic_cell.sv
module sim_logic_cell;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cfg_mode = 1'b0;
  logic       cfg_din = 1'b0;
  logic [3:0] din = '0;
  logic       cin = 1'b0;
  logic       ce = 1'b0;
  logic       sr = 1'b0;
  logic       cell_out, lut_out, cout;
  logic       cell1, lut1, cout1;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cycles = 0;

  always #5 clk = ~clk;

  logic_cell u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_din(cfg_din), .din(din),
    .cin(cin), .ce(ce), .sr(sr), .cell_out(cell_out), .lut_out(lut_out), .cout(cout)
  );

  logic_cell #(.HAS_IN(4'b0011), .HAS_SR(1'b0), .HAS_CE(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_din(cfg_din), .din(din),
    .cin(cin), .ce(ce), .sr(sr), .cell_out(cell1), .lut_out(lut1), .cout(cout1)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [20:0] mk_cfg(input logic neg, input logic asy, input logic srv,
                                         input logic reg_on, input logic car, input logic [15:0] t);
    return {neg, asy, srv, reg_on, car, t};
  endfunction

  // R11: first bit sent lands at bit 20
  task automatic load_cfg(input logic [20:0] w);
    for (int i = 20; i >= 0; i--) begin
      @(posedge clk); #2;
      cfg_mode = 1'b1;
      cfg_din  = w[i];
    end
    @(posedge clk); #2;
    cfg_mode = 1'b0;
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R12 lut_out", lut_out, 1'b0);
    check("R12 cout", cout, 1'b0);
    check("R12 cell_out", cell_out, 1'b0);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_lut(input logic [15:0] t, input logic reg_on);
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, reg_on, 1'b0, t));
    ce = 1'b0; sr = 1'b0;
    for (int k = 0; k < 16; k++) begin
      din = 4'(k); #1;
      if (reg_on) check("R9 lut_out while held", lut_out, t[k]);
      else begin
        check("R1 lut entry", lut_out, t[k]);
        check("R4 bypass", cell_out, t[k]);
      end
    end
  endtask

  task automatic t_carry;
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000));
    for (int k = 0; k < 8; k++) begin
      din = {1'b0, k[1], k[0], 1'b0}; cin = k[2]; #1;
      check("R2 carry", cout, (k[0] & k[1]) | ((k[0] | k[1]) & k[2]));
    end
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000));
    for (int k = 0; k < 8; k++) begin
      din = {1'b0, k[1], k[0], 1'b0}; cin = k[2]; #1;
      check("R3 carry off", cout, 1'b0);
    end
    cin = 1'b0;
  endtask

  task automatic t_sync;
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 16'h8000));
    din = 4'hF; ce = 1'b1; sr = 1'b0;
    step; check("R5 capture", cell_out, 1'b1);
    #1 din = 4'h0; ce = 1'b0;
    step; check("R5 ce low holds", cell_out, 1'b1);
    #1 ce = 1'b1;
    step; check("R5 capture zero", cell_out, 1'b0);
    #1 ce = 1'b0; sr = 1'b1;
    step; check("R6 sr without ce holds", cell_out, 1'b0);
    #1 ce = 1'b1;
    step; check("R6 sr loads value", cell_out, 1'b1);
    #1 sr = 1'b0; ce = 1'b0;
  endtask

  task automatic t_async;
    load_cfg(mk_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 16'hFFFF));
    ce = 1'b1; sr = 1'b0;
    step; check("R5 async-mode capture", cell_out, 1'b1);
    #1 ce = 1'b0; sr = 1'b1;
    #1 check("R7 immediate force", cell_out, 1'b0);
    step; #1 sr = 1'b0;
    step; check("R7 held after release, ce low", cell_out, 1'b0);
    #1 ce = 1'b1;
    step; check("R7 normal load after release", cell_out, 1'b1);
    #1 ce = 1'b0;
  endtask

  task automatic t_negedge;
    load_cfg(mk_cfg(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0002));
    ce = 1'b1; sr = 1'b0; din = 4'h0;
    @(posedge clk); #2;
    din = 4'h1;
    #2 check("R8 no rising capture", cell_out, 1'b0);
    #2 check("R8 falling capture", cell_out, 1'b1);
    ce = 1'b0;
  endtask

  task automatic t_cfg_hold;
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFFFF));
    ce = 1'b1; sr = 1'b0;
    step; check("R11 preload", cell_out, 1'b1);
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'h0000));
    #1 check("R11 held across shift", cell_out, 1'b1);
    check("R11 new table active", lut_out, 1'b0);
    step; check("R11 capture after load", cell_out, 1'b0);
    ce = 1'b0;
  endtask

  task automatic t_tieoff;
    load_cfg(mk_cfg(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 16'hFF0A));
    din = 4'b1100; ce = 1'b0; sr = 1'b1; #1;
    check("R10 unwired data read 0", lut1, 1'b0);
    check("R10 wired reference", lut_out, 1'b1);
    step; check("R10 ce tied high", cell1, 1'b0);
    #1 din = 4'b0001;
    step; check("R10 sr tied low", cell1, 1'b1);
    #1 sr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset;
    t_lut(16'hA5C3, 1'b0);
    t_lut(16'h6996, 1'b0);
    t_lut(16'h3C5A, 1'b1);
    t_carry;
    t_sync;
    t_async;
    t_negedge;
    t_cfg_hold;
    t_tieoff;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule